// File: doc/BRIEF.md
# Debug halt entry controller

This block keeps the run/halt state of one processing element for an external debugger. It watches a set of event pulses from the core: a debugger halt request, restart, halting-breakpoint instruction commit, instruction retire, exception entry and exception return with the target exception level, core reset release, a debug-register system access, the OS lock level, and breakpoint and watchpoint hits. Each kind of event can be enabled on its own. The block turns the enabled events into a single decision to enter Debug state.

Once halted, the block stays halted until a restart request arrives. It latches a code that says which cause won the halt. It also drives a hold signal that tells the pipeline not to start the next instruction. The hold signal is raised in the same cycle that a cause is seen, so the pipeline stops even though the halted flag only rises one clock later. Control bits are loaded through a plain write port. The control bits survive a core reset that is reported through the reset-release pulse, which is what allows reset catch to work.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, `halted` is 0, `halt_reason` is 0 (none), `hold_next` is 0 when no cause is present, and every control bit is 0.
- R2: While running, `ext_halt_req` sets `halted` at the next edge with reason code 1. While halted, the request is ignored and the reason stays unchanged.
- R3: Only `restart_req` leaves Debug state: `halted` falls at the edge that samples it. A restart seen while running has no effect.
- R4: `hlt_commit` halts with reason 5 only when the halting-debug enable is set. This enable is bit 0 of write address 0.
- R5: If the step bit (bit 1 of address 0) is 1 when a restart is taken, the first later `insn_retire` or `exc_entry` halts the block with reason 4. Cycles without such a pulse do not halt. A restart taken with the step bit at 0 arms nothing.
- R6: Exception catch halts with reason 3. On `exc_entry`, bit `exc_level` of address 1 enables the catch. On `exc_return`, bit `exc_level` of address 2 enables it. A bit for any other level has no effect.
- R7: With reset catch (bit 2 of address 0) set, a `core_rst_done` pulse halts with reason 2, before the first instruction executes.
- R8: With the debug-access trap bit (bit 3 of address 0) set, `dbg_reg_acc` halts with reason 6 unless `dbg_reg_acc_mmio` marks the access as memory-mapped.
- R9: With OS-unlock catch (bit 4 of address 0) set, a 1-to-0 change of `os_lock` while running halts with reason 7.
- R10: `bkpt_hit` (reason 8) and `wpt_hit` (reason 9) halt only when the halting-debug enable and `dbg_auth_ok` are both 1.
- R11: When several causes are present in one cycle, the smallest code wins: 1 external, 2 reset catch, 3 exception catch, 4 step, 5 halting instruction, 6 debug-register access, 7 OS unlock, 8 breakpoint, 9 watchpoint.
- R12: `hold_next` is 1 whenever `halted` is 1, or when a halt cause is present in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control write strobe |
| cfg_wr_addr | input | 2 | Control write address (0 control, 1 entry catch, 2 return catch) |
| cfg_wr_data | input | 8 | Control write data |
| ext_halt_req | input | 1 | Debugger halt request |
| restart_req | input | 1 | Debugger restart request |
| hlt_commit | input | 1 | Halting-breakpoint instruction committed |
| insn_retire | input | 1 | An instruction retired |
| exc_entry | input | 1 | Exception taken |
| exc_return | input | 1 | Exception return executed |
| exc_level | input | 2 | Target exception level of entry or return |
| core_rst_done | input | 1 | Core leaves warm or cold reset |
| dbg_reg_acc | input | 1 | Access to breakpoint or watchpoint value or control register |
| dbg_reg_acc_mmio | input | 1 | That access is memory-mapped |
| os_lock | input | 1 | OS lock level |
| bkpt_hit | input | 1 | Breakpoint match |
| wpt_hit | input | 1 | Watchpoint match |
| dbg_auth_ok | input | 1 | Debug allowed in current security state |
| halted | output | 1 | Processing element is in Debug state |
| hold_next | output | 1 | Do not start the next instruction |
| halt_reason | output | 4 | Code of the cause that won the last halt |

## Verification
`hold_next` is combinational, so it is due in the same cycle as the cause that raises it. The bench samples it one time unit after it drives the inputs, which is before the clock edge. `halted` and `halt_reason` are due one edge after the cause or restart is sampled. A control write takes effect from the edge that stores it, so the write cannot affect causes in the same cycle. The bench's behavioural model follows these same timings: it computes the cause from the control state that applied before the edge and only then applies writes, restart and the OS-lock history. All three outputs are compared in every cycle.

// File: rtl/dbg_halt_pkg.sv
// Shared types for the debug halt entry controller.
// Assumes the reason code order is the fixed halt priority (lower code wins).
package dbg_halt_pkg;

    localparam int REASON_W  = 4;
    localparam int NUM_CAUSE = 9;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE  = 4'd0,
        RSN_EXT   = 4'd1,
        RSN_RSTC  = 4'd2,
        RSN_EXCC  = 4'd3,
        RSN_STEP  = 4'd4,
        RSN_HLT   = 4'd5,
        RSN_SWACC = 4'd6,
        RSN_OSUL  = 4'd7,
        RSN_BKPT  = 4'd8,
        RSN_WPT   = 4'd9
    } reason_e;

    // Bit positions in the main control word (write address 0)
    localparam int CB_HDE   = 0;
    localparam int CB_STEP  = 1;
    localparam int CB_RSTC  = 2;
    localparam int CB_TRAP  = 3;
    localparam int CB_OSUC  = 4;

    typedef struct packed {
        logic osuc_en;
        logic trap_en;
        logic rstc_en;
        logic step_en;
        logic hde;
    } ctrl_t;

endpackage

// File: rtl/dbg_cfg_regs.sv
// Control register file: the main control word and the per-level exception
// catch enables for entry and return. Assumes a single write per cycle and
// that written values take effect from the next cycle.
module dbg_cfg_regs
    import dbg_halt_pkg::*;
#(
    parameter int NUM_EL = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [NUM_EL-1:0] catch_entry,
    output logic [NUM_EL-1:0] catch_ret
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ENT  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RET  = ADDR_W'(2);

    // Store the control word on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            ctrl.hde     <= wr_data[CB_HDE];
            ctrl.step_en <= wr_data[CB_STEP];
            ctrl.rstc_en <= wr_data[CB_RSTC];
            ctrl.trap_en <= wr_data[CB_TRAP];
            ctrl.osuc_en <= wr_data[CB_OSUC];
        end
    end

    // One enable flop pair per exception level
    for (genvar el = 0; el < NUM_EL; el++) begin : g_level
        // Store the entry and return catch bits for this level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                catch_entry[el] <= 1'b0;
                catch_ret[el]   <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr == A_ENT) catch_entry[el] <= wr_data[el];
                if (wr_addr == A_RET) catch_ret[el]   <= wr_data[el];
            end
        end
    end
endmodule

// File: rtl/dbg_cause_eval.sv
// Turns the event pulses and the enables into a cause vector and picks the
// winner by fixed priority. Assumes the pulses are valid for one cycle each and
// that os_lock is a level. Causes are ignored while halted.
module dbg_cause_eval
    import dbg_halt_pkg::*;
#(
    parameter int NUM_EL = 4,
    localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halted,
    input  logic                step_armed,
    input  ctrl_t               ctrl,
    input  logic [NUM_EL-1:0]   catch_entry,
    input  logic [NUM_EL-1:0]   catch_ret,
    input  logic                ext_halt_req,
    input  logic                hlt_commit,
    input  logic                insn_retire,
    input  logic                exc_entry,
    input  logic                exc_return,
    input  logic [EL_W-1:0]     exc_level,
    input  logic                core_rst_done,
    input  logic                dbg_reg_acc,
    input  logic                dbg_reg_acc_mmio,
    input  logic                os_lock,
    input  logic                bkpt_hit,
    input  logic                wpt_hit,
    input  logic                dbg_auth_ok,
    output logic                cause_any,
    output logic [REASON_W-1:0] cause_code
);
    logic                 os_lock_q;
    logic [NUM_CAUSE-1:0] cause;
    logic                 exc_hit;

    // Remember the previous OS lock level to spot the unlock edge
    always_ff @(posedge clk) begin
        if (!rst_n) os_lock_q <= 1'b0;
        else        os_lock_q <= os_lock;
    end

    // Look up the catch enable for the target level of the exception
    always_comb begin
        exc_hit = (exc_entry  && catch_entry[exc_level])
               || (exc_return && catch_ret[exc_level]);
    end

    // Form each enabled cause; bit k stands for reason code k+1
    always_comb begin
        cause = '0;
        if (!halted) begin
            cause[RSN_EXT  - 1] = ext_halt_req;
            cause[RSN_RSTC - 1] = core_rst_done && ctrl.rstc_en;
            cause[RSN_EXCC - 1] = exc_hit;
            cause[RSN_STEP - 1] = step_armed && (insn_retire || exc_entry);
            cause[RSN_HLT  - 1] = hlt_commit && ctrl.hde;
            cause[RSN_SWACC- 1] = dbg_reg_acc && !dbg_reg_acc_mmio && ctrl.trap_en;
            cause[RSN_OSUL - 1] = os_lock_q && !os_lock && ctrl.osuc_en;
            cause[RSN_BKPT - 1] = bkpt_hit && ctrl.hde && dbg_auth_ok;
            cause[RSN_WPT  - 1] = wpt_hit  && ctrl.hde && dbg_auth_ok;
        end
    end

    // Fixed-priority pick: the lowest set index wins
    always_comb begin
        cause_code = RSN_NONE;
        for (int k = NUM_CAUSE - 1; k >= 0; k--) begin
            if (cause[k]) cause_code = REASON_W'(k + 1);
        end
        cause_any = |cause;
    end
endmodule

// File: rtl/dbg_run_state.sv
// Run/halt state, latched halt reason and the single-step arm flag.
// Assumes a cause is only presented while running; restart is only acted on
// while halted.
module dbg_run_state
    import dbg_halt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_req,
    input  logic                step_en,
    input  logic                cause_any,
    input  logic [REASON_W-1:0] cause_code,
    output logic                halted,
    output logic                step_armed,
    output logic [REASON_W-1:0] halt_reason
);
    // Enter on a cause, leave on restart, arm a step at restart if enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted      <= 1'b0;
            step_armed  <= 1'b0;
            halt_reason <= RSN_NONE;
        end else if (halted) begin
            if (restart_req) begin
                halted     <= 1'b0;
                step_armed <= step_en;
            end
        end else if (cause_any) begin
            halted      <= 1'b1;
            step_armed  <= 1'b0;
            halt_reason <= cause_code;
        end
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
// Top of the debug halt entry controller. It ties the control registers, the
// cause evaluation and the run/halt state together. It assumes every event
// input is a single-cycle pulse, except os_lock and dbg_auth_ok, which are levels.
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int NUM_EL = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_wr_addr,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    input  logic                ext_halt_req,
    input  logic                restart_req,
    input  logic                hlt_commit,
    input  logic                insn_retire,
    input  logic                exc_entry,
    input  logic                exc_return,
    input  logic [EL_W-1:0]     exc_level,
    input  logic                core_rst_done,
    input  logic                dbg_reg_acc,
    input  logic                dbg_reg_acc_mmio,
    input  logic                os_lock,
    input  logic                bkpt_hit,
    input  logic                wpt_hit,
    input  logic                dbg_auth_ok,
    output logic                halted,
    output logic                hold_next,
    output logic [REASON_W-1:0] halt_reason
);
    ctrl_t               ctrl;
    logic [NUM_EL-1:0]   catch_entry;
    logic [NUM_EL-1:0]   catch_ret;
    logic                cause_any;
    logic [REASON_W-1:0] cause_code;
    logic                step_armed;

    dbg_cfg_regs #(.NUM_EL(NUM_EL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .ctrl(ctrl), .catch_entry(catch_entry), .catch_ret(catch_ret)
    );

    dbg_cause_eval #(.NUM_EL(NUM_EL)) u_cause (
        .clk(clk), .rst_n(rst_n),
        .halted(halted), .step_armed(step_armed), .ctrl(ctrl),
        .catch_entry(catch_entry), .catch_ret(catch_ret),
        .ext_halt_req(ext_halt_req), .hlt_commit(hlt_commit),
        .insn_retire(insn_retire), .exc_entry(exc_entry),
        .exc_return(exc_return), .exc_level(exc_level),
        .core_rst_done(core_rst_done), .dbg_reg_acc(dbg_reg_acc),
        .dbg_reg_acc_mmio(dbg_reg_acc_mmio), .os_lock(os_lock),
        .bkpt_hit(bkpt_hit), .wpt_hit(wpt_hit), .dbg_auth_ok(dbg_auth_ok),
        .cause_any(cause_any), .cause_code(cause_code)
    );

    dbg_run_state u_state (
        .clk(clk), .rst_n(rst_n),
        .restart_req(restart_req), .step_en(ctrl.step_en),
        .cause_any(cause_any), .cause_code(cause_code),
        .halted(halted), .step_armed(step_armed), .halt_reason(halt_reason)
    );

    // Stop issue at once on a cause, and for as long as halted
    always_comb begin
        hold_next = halted || cause_any;
    end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
// Property checker for the debug halt entry controller, bound to the top.
// Assumes the synchronous active-low reset of the top.
module dbg_halt_ctrl_chk #(
    parameter int REASON_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ext_halt_req,
    input logic                restart_req,
    input logic                halted,
    input logic                hold_next,
    input logic [REASON_W-1:0] halt_reason
);
    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !restart_req |=> halted); // R3
    AST_RESTART_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && restart_req |=> !halted); // R3
    AST_EXT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        !halted && ext_halt_req |=> halted && halt_reason == REASON_W'(1)); // R2
    AST_REASON_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !restart_req |=> $stable(halt_reason)); // R2
    AST_HOLD_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> hold_next); // R12
    AST_NO_SILENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !halted && !hold_next |=> !halted); // R12
    AST_ENTRY_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> halt_reason != '0); // R11
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.REASON_W(dbg_halt_pkg::REASON_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_halt_req(ext_halt_req),
    .restart_req(restart_req), .halted(halted), .hold_next(hold_next),
    .halt_reason(halt_reason)
);

// File: tb/dbg_halt_ctrl_tb_top.sv
// Bench for the debug halt entry controller: a behavioural reference model
// that is compared with the outputs in every cycle.
module dbg_halt_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 0;
    logic [1:0] cfg_wr_addr = 0;
    logic [7:0] cfg_wr_data = 0;
    logic       ext_halt_req = 0, restart_req = 0, hlt_commit = 0, insn_retire = 0;
    logic       exc_entry = 0, exc_return = 0;
    logic [1:0] exc_level = 0;
    logic       core_rst_done = 0, dbg_reg_acc = 0, dbg_reg_acc_mmio = 0;
    logic       os_lock = 0, bkpt_hit = 0, wpt_hit = 0, dbg_auth_ok = 0;
    logic       halted, hold_next;
    logic [3:0] halt_reason;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .ext_halt_req(ext_halt_req),
        .restart_req(restart_req), .hlt_commit(hlt_commit),
        .insn_retire(insn_retire), .exc_entry(exc_entry), .exc_return(exc_return),
        .exc_level(exc_level), .core_rst_done(core_rst_done),
        .dbg_reg_acc(dbg_reg_acc), .dbg_reg_acc_mmio(dbg_reg_acc_mmio),
        .os_lock(os_lock), .bkpt_hit(bkpt_hit), .wpt_hit(wpt_hit),
        .dbg_auth_ok(dbg_auth_ok), .halted(halted), .hold_next(hold_next),
        .halt_reason(halt_reason)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference model state
    int m_halted = 0, m_reason = 0, m_step_arm = 0, m_os_prev = 0;
    int m_hde = 0, m_step = 0, m_rstc = 0, m_trap = 0, m_osuc = 0;
    int m_ent[4] = '{0, 0, 0, 0};
    int m_ret[4] = '{0, 0, 0, 0};

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Code of the cause the model sees this cycle, 0 when none
    function automatic int m_cause();
        if (m_halted != 0) return 0;
        if (ext_halt_req) return 1;
        if (core_rst_done && m_rstc != 0) return 2;
        if ((exc_entry && m_ent[exc_level] != 0) || (exc_return && m_ret[exc_level] != 0)) return 3;
        if (m_step_arm != 0 && (insn_retire || exc_entry)) return 4;
        if (hlt_commit && m_hde != 0) return 5;
        if (dbg_reg_acc && !dbg_reg_acc_mmio && m_trap != 0) return 6;
        if (m_os_prev != 0 && !os_lock && m_osuc != 0) return 7;
        if (bkpt_hit && m_hde != 0 && dbg_auth_ok) return 8;
        if (wpt_hit && m_hde != 0 && dbg_auth_ok) return 9;
        return 0;
    endfunction

    // One clock: check the hold output, let the edge pass, update model, compare
    task automatic cycle();
        int c;
        #1;
        c = m_cause();
        check("hold_next", int'(hold_next), (m_halted != 0 || c != 0) ? 1 : 0); // R12
        @(posedge clk);
        if (!rst_n) begin
            m_halted = 0; m_reason = 0; m_step_arm = 0; m_os_prev = 0;
            m_hde = 0; m_step = 0; m_rstc = 0; m_trap = 0; m_osuc = 0;
            for (int i = 0; i < 4; i++) begin m_ent[i] = 0; m_ret[i] = 0; end
        end else begin
            if (m_halted != 0) begin
                if (restart_req) begin m_halted = 0; m_step_arm = m_step; end
            end else if (c != 0) begin
                m_halted = 1; m_reason = c; m_step_arm = 0;
            end
            if (cfg_wr_en) begin
                case (cfg_wr_addr)
                    2'd0: begin
                        m_hde = cfg_wr_data[0]; m_step = cfg_wr_data[1];
                        m_rstc = cfg_wr_data[2]; m_trap = cfg_wr_data[3];
                        m_osuc = cfg_wr_data[4];
                    end
                    2'd1: for (int i = 0; i < 4; i++) m_ent[i] = cfg_wr_data[i];
                    2'd2: for (int i = 0; i < 4; i++) m_ret[i] = cfg_wr_data[i];
                    default: ;
                endcase
            end
            m_os_prev = os_lock;
        end
        @(negedge clk);
        check("halted", int'(halted), m_halted);
        check("halt_reason", int'(halt_reason), m_reason);
        cfg_wr_en = 0; ext_halt_req = 0; restart_req = 0; hlt_commit = 0;
        insn_retire = 0; exc_entry = 0; exc_return = 0; core_rst_done = 0;
        dbg_reg_acc = 0; dbg_reg_acc_mmio = 0; bkpt_hit = 0; wpt_hit = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d; cycle();
    endtask

    task automatic restart();
        restart_req = 1; cycle();
    endtask

    task automatic force_halt();
        ext_halt_req = 1; cycle();
    endtask

    initial begin
        @(negedge clk);
        tag = "R1"; idle(3);
        rst_n = 1;
        idle(2);
        check("halted after reset R1", int'(halted), 0);
        check("halt_reason after reset R1", int'(halt_reason), 0);

        tag = "R4"; hlt_commit = 1; cycle(); idle(1);   // halting-debug disabled
        wr(2'd0, 8'h01);
        hlt_commit = 1; cycle(); idle(2); restart(); idle(1);

        tag = "R3"; restart(); idle(1);                 // restart while running
        force_halt(); idle(4);
        tag = "R2"; ext_halt_req = 1; cycle();          // ignored while halted
        hlt_commit = 1; cycle(); idle(1);
        tag = "R3"; restart(); idle(1);

        tag = "R5"; force_halt(); wr(2'd0, 8'h03); restart();
        idle(3); insn_retire = 1; cycle(); idle(1);
        restart(); exc_entry = 1; exc_level = 2'd1; cycle(); idle(1);
        wr(2'd0, 8'h01); restart(); insn_retire = 1; cycle(); insn_retire = 1; cycle();

        tag = "R6"; wr(2'd1, 8'h04); wr(2'd2, 8'h02);
        exc_entry = 1; exc_level = 2'd1; cycle();
        exc_return = 1; exc_level = 2'd2; cycle();
        exc_entry = 1; exc_level = 2'd2; cycle(); restart();
        exc_return = 1; exc_level = 2'd1; cycle(); restart();
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        tag = "R7"; core_rst_done = 1; cycle();
        wr(2'd0, 8'h05); core_rst_done = 1; cycle(); idle(1); restart();

        tag = "R8"; dbg_reg_acc = 1; cycle();
        wr(2'd0, 8'h09); dbg_reg_acc = 1; dbg_reg_acc_mmio = 1; cycle();
        dbg_reg_acc = 1; cycle(); restart();

        tag = "R9"; os_lock = 1; cycle(); os_lock = 0; cycle();
        wr(2'd0, 8'h11); os_lock = 1; idle(2); os_lock = 0; cycle(); restart();

        tag = "R10"; wr(2'd0, 8'h00); dbg_auth_ok = 1;
        bkpt_hit = 1; cycle(); wpt_hit = 1; cycle();
        wr(2'd0, 8'h01); dbg_auth_ok = 0; bkpt_hit = 1; cycle(); wpt_hit = 1; cycle();
        dbg_auth_ok = 1; bkpt_hit = 1; cycle(); restart();
        wpt_hit = 1; cycle(); restart();

        tag = "R11"; wr(2'd0, 8'h1D); wr(2'd1, 8'h0F);
        ext_halt_req = 1; wpt_hit = 1; core_rst_done = 1; cycle(); restart();
        core_rst_done = 1; exc_entry = 1; exc_level = 2'd3; hlt_commit = 1; cycle(); restart();
        bkpt_hit = 1; wpt_hit = 1; cycle(); restart();
        hlt_commit = 1; dbg_reg_acc = 1; bkpt_hit = 1; cycle(); restart();
        os_lock = 1; cycle(); os_lock = 0; dbg_reg_acc = 1; cycle(); restart();
        os_lock = 1; cycle(); os_lock = 0; wpt_hit = 1; cycle(); restart();

        tag = "R1"; rst_n = 0; cycle(); rst_n = 1; idle(1);
        hlt_commit = 1; core_rst_done = 1; cycle();      // enables cleared by reset
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule